// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of an 8-bit accumulator processor. Each cycle it can accept one operation. The operation comes with the current accumulator, both index registers, the stack pointer and a memory operand. One clock later the block returns a result byte, a destination code and a write strobe for the register file. It also keeps its own status register, which holds the negative, overflow, decimal, interrupt-disable, zero and carry flags.

The operations are: add with carry, subtract with borrow, compare against any of the three data registers, bit test, the three bitwise logic operations, the register transfers, and explicit set and clear operations on single flags. Decimal arithmetic is not part of this stage. The decimal flag is only held so that the rest of the processor can read it.

A sequencer drives `opValid` for one cycle per operation. It then watches `doneOut` and `wrEnOut` on the following cycle. When `wrEnOut` is high, it writes `resultOut` into the register named by `destOut`.

Top module: `acc_alu`

## Requirements
- R1: After reset, `statusOut` is 8'h04, so only the interrupt-disable flag is set. `doneOut` and `wrEnOut` are 0.
- R2: An operation is accepted on a clock edge where `opValid` is 1. Its outputs, including the updated `statusOut`, appear after that edge, and `doneOut` is 1 for that one cycle. A cycle with `opValid` at 0 leaves `doneOut` and `wrEnOut` at 0 and holds every flag.
- R3: Add (code 1) writes A+M+C to A (`destOut` 0). N and Z follow the result and C is the carry out. V is 1 when A and M have the same sign but the result has the other sign.
- R4: Subtract (code 2) writes A−M−(1−C) to A. C is 1 when no borrow occurred. V uses the add rule with M inverted. N and Z follow the result.
- R5: Compare (code 3 for A, 4 for X, 5 for Y) writes nothing. It sets C to 1 when the register is greater than or equal to M (unsigned), and sets N and Z from register−M. V is held.
- R6: Bit test (code 6) writes nothing. Z is 1 when A AND M is zero, N takes M bit 7 and V takes M bit 6. C is held.
- R7: AND (code 7), OR (code 8) and exclusive OR (code 9) write to A and change only N and Z.
- R8: The transfers A→X (10), A→Y (11), X→A (12), Y→A (13) and S→X (14) write the moved byte to the target and set N and Z from it. The destination codes are A=0, X=1, Y=2, S=3.
- R9: The transfer X→S (code 15) writes X to destination 3 and changes no flag.
- R10: These codes change only the named flag: clear C (16), set C (17), clear D (18), set D (19), clear I (20), set I (21), clear V (22). None of them writes a register.
- R11: The D flag never changes the adder. With D set, add and subtract still give binary results.
- R12: The codes 0 and 23–31 pulse `doneOut`, write nothing and change no flag.
- R13: The layout of `statusOut` is: N at bit 7, V at bit 6, D at bit 3, I at bit 2, Z at bit 1, C at bit 0. Bits 5 and 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Accept the operation on this edge |
| opCode | input | 5 | Operation code (see requirements) |
| accIn | input | DATA_W | Accumulator operand |
| xIn | input | DATA_W | X index operand |
| yIn | input | DATA_W | Y index operand |
| spIn | input | DATA_W | Stack pointer operand |
| memIn | input | DATA_W | Memory operand |
| resultOut | output | DATA_W | Result byte |
| destOut | output | 2 | Destination register code |
| wrEnOut | output | 1 | Write `resultOut` to `destOut` |
| doneOut | output | 1 | An operation completed this cycle |
| statusOut | output | 8 | Status register |

## Verification
The bench builds the block with the default `DATA_W` of 8. At that width a short, hand-picked set of operand pairs covers every edge case. These include the carry out of 0xFF+1, the two signed overflow corners at 0x7F/0x80 for both add and subtract, a subtract that underflows to 0xFF, and compares where the register is equal to, below and above M. Operations run back to back, so each one also checks that flags carried over from the previous operation (the carry, and a held V or C) are used correctly.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,  OP_ADC  = 5'd1,  OP_SBC  = 5'd2,  OP_CMPA = 5'd3,
    OP_CMPX = 5'd4,  OP_CMPY = 5'd5,  OP_BIT  = 5'd6,  OP_AND  = 5'd7,
    OP_OR   = 5'd8,  OP_EOR  = 5'd9,  OP_TAX  = 5'd10, OP_TAY  = 5'd11,
    OP_TXA  = 5'd12, OP_TYA  = 5'd13, OP_TSX  = 5'd14, OP_TXS  = 5'd15,
    OP_CLC  = 5'd16, OP_SEC  = 5'd17, OP_CLD  = 5'd18, OP_SED  = 5'd19,
    OP_CLI  = 5'd20, OP_SEI  = 5'd21, OP_CLV  = 5'd22
  } aluOp_e;

  typedef enum logic [1:0] {DST_A = 2'd0, DST_X = 2'd1, DST_Y = 2'd2, DST_S = 2'd3} dest_e;
  typedef enum logic [1:0] {LHS_A, LHS_X, LHS_Y, LHS_S} lhs_e;
  typedef enum logic [2:0] {OUT_SUM, OUT_AND, OUT_OR, OUT_EOR, OUT_PASS} outSrc_e;
  typedef enum logic [1:0] {FS_C, FS_D, FS_I, FS_V} flagSel_e;

  localparam int ST_N = 7;
  localparam int ST_V = 6;
  localparam int ST_D = 3;
  localparam int ST_I = 2;
  localparam int ST_Z = 1;
  localparam int ST_C = 0;

  typedef struct packed {
    lhs_e     lhsSel;
    outSrc_e  outSrc;
    logic     invMem;
    logic     useCarry;
    logic     carryForce;
    logic     ldNZ;
    logic     ldC;
    logic     ldV;
    logic     bitTest;
    logic     wrRes;
    dest_e    dest;
    logic     flagWr;
    flagSel_e flagSel;
    logic     flagVal;
  } strobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  aluOp_e  opCode,
  output strobe_t stb
);

  always_comb begin
    stb = '0;
    case (opCode)
      OP_ADC: begin
        stb.useCarry = 1'b1; stb.ldNZ = 1'b1; stb.ldC = 1'b1; stb.ldV = 1'b1;
        stb.wrRes = 1'b1; stb.dest = DST_A;
      end
      OP_SBC: begin
        stb.invMem = 1'b1; stb.useCarry = 1'b1;
        stb.ldNZ = 1'b1; stb.ldC = 1'b1; stb.ldV = 1'b1;
        stb.wrRes = 1'b1; stb.dest = DST_A;
      end
      OP_CMPA, OP_CMPX, OP_CMPY: begin
        stb.lhsSel = (opCode == OP_CMPX) ? LHS_X :
                     (opCode == OP_CMPY) ? LHS_Y : LHS_A;
        stb.invMem = 1'b1; stb.carryForce = 1'b1;
        stb.ldNZ = 1'b1; stb.ldC = 1'b1;
      end
      OP_BIT: begin
        stb.outSrc = OUT_AND; stb.bitTest = 1'b1;
      end
      OP_AND, OP_OR, OP_EOR: begin
        stb.outSrc = (opCode == OP_AND) ? OUT_AND :
                     (opCode == OP_OR)  ? OUT_OR  : OUT_EOR;
        stb.ldNZ = 1'b1; stb.wrRes = 1'b1; stb.dest = DST_A;
      end
      OP_TAX: begin
        stb.outSrc = OUT_PASS; stb.lhsSel = LHS_A; stb.ldNZ = 1'b1;
        stb.wrRes = 1'b1; stb.dest = DST_X;
      end
      OP_TAY: begin
        stb.outSrc = OUT_PASS; stb.lhsSel = LHS_A; stb.ldNZ = 1'b1;
        stb.wrRes = 1'b1; stb.dest = DST_Y;
      end
      OP_TXA: begin
        stb.outSrc = OUT_PASS; stb.lhsSel = LHS_X; stb.ldNZ = 1'b1;
        stb.wrRes = 1'b1; stb.dest = DST_A;
      end
      OP_TYA: begin
        stb.outSrc = OUT_PASS; stb.lhsSel = LHS_Y; stb.ldNZ = 1'b1;
        stb.wrRes = 1'b1; stb.dest = DST_A;
      end
      OP_TSX: begin
        stb.outSrc = OUT_PASS; stb.lhsSel = LHS_S; stb.ldNZ = 1'b1;
        stb.wrRes = 1'b1; stb.dest = DST_X;
      end
      OP_TXS: begin
        stb.outSrc = OUT_PASS; stb.lhsSel = LHS_X;
        stb.wrRes = 1'b1; stb.dest = DST_S;
      end
      OP_CLC: begin stb.flagWr = 1'b1; stb.flagSel = FS_C; stb.flagVal = 1'b0; end
      OP_SEC: begin stb.flagWr = 1'b1; stb.flagSel = FS_C; stb.flagVal = 1'b1; end
      OP_CLD: begin stb.flagWr = 1'b1; stb.flagSel = FS_D; stb.flagVal = 1'b0; end
      OP_SED: begin stb.flagWr = 1'b1; stb.flagSel = FS_D; stb.flagVal = 1'b1; end
      OP_CLI: begin stb.flagWr = 1'b1; stb.flagSel = FS_I; stb.flagVal = 1'b0; end
      OP_SEI: begin stb.flagWr = 1'b1; stb.flagSel = FS_I; stb.flagVal = 1'b1; end
      OP_CLV: begin stb.flagWr = 1'b1; stb.flagSel = FS_V; stb.flagVal = 1'b0; end
      default: stb = '0;
    endcase
  end

endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] xIn,
  input  logic [DATA_W-1:0] yIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] memIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [1:0]        destOut,
  output logic              wrEnOut,
  output logic              doneOut,
  output logic [7:0]        statusOut
);

  localparam int MSB = DATA_W - 1;

  logic nQ, vQ, dQ, iQ, zQ, cQ;
  logic [DATA_W-1:0] lhs, memOp, resNxt;
  logic [DATA_W:0]   sumW;
  logic              cin, sumOvf;
  logic              nNxt, vNxt, dNxt, iNxt, zNxt, cNxt;

  always_comb begin
    case (stb.lhsSel)
      LHS_X:   lhs = xIn;
      LHS_Y:   lhs = yIn;
      LHS_S:   lhs = spIn;
      default: lhs = accIn;
    endcase
  end

  assign memOp  = stb.invMem ? ~memIn : memIn;
  assign cin    = stb.useCarry ? cQ : stb.carryForce;
  assign sumW   = {1'b0, lhs} + {1'b0, memOp} + {{DATA_W{1'b0}}, cin};
  assign sumOvf = (lhs[MSB] == memOp[MSB]) && (sumW[MSB] != lhs[MSB]);

  always_comb begin
    case (stb.outSrc)
      OUT_AND:  resNxt = lhs & memIn;
      OUT_OR:   resNxt = lhs | memIn;
      OUT_EOR:  resNxt = lhs ^ memIn;
      OUT_PASS: resNxt = lhs;
      default:  resNxt = sumW[MSB:0];
    endcase
  end

  always_comb begin
    nNxt = nQ; vNxt = vQ; dNxt = dQ; iNxt = iQ; zNxt = zQ; cNxt = cQ;
    if (stb.ldNZ) begin
      nNxt = resNxt[MSB];
      zNxt = (resNxt == '0);
    end
    if (stb.ldC) cNxt = sumW[DATA_W];
    if (stb.ldV) vNxt = sumOvf;
    if (stb.bitTest) begin
      nNxt = memIn[MSB];
      vNxt = memIn[MSB-1];
      zNxt = (resNxt == '0);
    end
    if (stb.flagWr) begin
      case (stb.flagSel)
        FS_C:    cNxt = stb.flagVal;
        FS_D:    dNxt = stb.flagVal;
        FS_I:    iNxt = stb.flagVal;
        default: vNxt = stb.flagVal;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {nQ, vQ, dQ, zQ, cQ} <= '0;
      iQ        <= 1'b1;
      resultOut <= '0;
      destOut   <= DST_A;
      wrEnOut   <= 1'b0;
      doneOut   <= 1'b0;
    end else begin
      doneOut <= opValid;
      wrEnOut <= opValid && stb.wrRes;
      if (opValid) begin
        {nQ, vQ, dQ, iQ, zQ, cQ} <= {nNxt, vNxt, dNxt, iNxt, zNxt, cNxt};
        resultOut <= resNxt;
        destOut   <= stb.dest;
      end
    end
  end

  assign statusOut = {nQ, vQ, 2'b00, dQ, iQ, zQ, cQ};

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(statusOut) && !doneOut && !wrEnOut));

  // R2
  wr_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEnOut |-> doneOut);

  // R11
  dflag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !(stb.flagWr && stb.flagSel == FS_D)) |=> $stable(dQ));

  // R5
  cmp_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && stb.ldC && !stb.wrRes) |=> (cQ == ($past(lhs) >= $past(memIn))));

  // R6
  bit_nv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && stb.bitTest) |=> (nQ == $past(memIn[MSB]) && vQ == $past(memIn[MSB-1]) && $stable(cQ)));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [4:0]        opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] xIn,
  input  logic [DATA_W-1:0] yIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] memIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [1:0]        destOut,
  output logic              wrEnOut,
  output logic              doneOut,
  output logic [7:0]        statusOut
);

  strobe_t stb;

  alu_ctrl u_ctrl (
    .opCode (aluOp_e'(opCode)),
    .stb    (stb)
  );

  alu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .stb       (stb),
    .accIn     (accIn),
    .xIn       (xIn),
    .yIn       (yIn),
    .spIn      (spIn),
    .memIn     (memIn),
    .resultOut (resultOut),
    .destOut   (destOut),
    .wrEnOut   (wrEnOut),
    .doneOut   (doneOut),
    .statusOut (statusOut)
  );

endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  import alu_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] accIn = '0, xIn = '0, yIn = '0, spIn = '0, memIn = '0;
  logic [7:0] resultOut, statusOut;
  logic [1:0] destOut;
  logic wrEnOut, doneOut;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int unsigned res;
    int unsigned dest;
    bit          wr;
    int unsigned st;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  // model flags
  bit mN = 0, mV = 0, mD = 0, mI = 1, mZ = 0, mC = 0;

  always #2.5 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .accIn(accIn), .xIn(xIn), .yIn(yIn), .spIn(spIn), .memIn(memIn),
    .resultOut(resultOut), .destOut(destOut), .wrEnOut(wrEnOut),
    .doneOut(doneOut), .statusOut(statusOut)
  );

  function automatic int sg(int unsigned v);
    return (v >= 128) ? int'(v) - 256 : int'(v);
  endfunction

  function automatic int unsigned stWord();
    return {24'd0, mN, mV, 2'b00, mD, mI, mZ, mC};
  endfunction

  task automatic issueOp(input int unsigned op, input int unsigned a, input int unsigned x,
                         input int unsigned y, input int unsigned s, input int unsigned m,
                         input string tag);
    exp_t e;
    int t, sv, r;
    e.res = 0; e.dest = 0; e.wr = 0; e.tag = tag;
    case (op)
      1: begin
        t = int'(a) + int'(m) + int'(mC); sv = sg(a) + sg(m) + int'(mC);
        e.res = t % 256; mC = (t > 255); mV = (sv > 127 || sv < -128);
        e.wr = 1; e.dest = 0;
      end
      2: begin
        t = int'(a) - int'(m) - (1 - int'(mC)); sv = sg(a) - sg(m) - (1 - int'(mC));
        e.res = (t + 256) % 256; mC = (t >= 0); mV = (sv > 127 || sv < -128);
        e.wr = 1; e.dest = 0;
      end
      3, 4, 5: begin
        r = (op == 3) ? int'(a) : (op == 4) ? int'(x) : int'(y);
        t = r - int'(m); e.res = (t + 256) % 256; mC = (r >= int'(m));
      end
      6: begin
        mZ = ((a & m) == 0); mN = m[7]; mV = m[6];
      end
      7: begin e.res = a & m; e.wr = 1; e.dest = 0; end
      8: begin e.res = a | m; e.wr = 1; e.dest = 0; end
      9: begin e.res = a ^ m; e.wr = 1; e.dest = 0; end
      10: begin e.res = a; e.wr = 1; e.dest = 1; end
      11: begin e.res = a; e.wr = 1; e.dest = 2; end
      12: begin e.res = x; e.wr = 1; e.dest = 0; end
      13: begin e.res = y; e.wr = 1; e.dest = 0; end
      14: begin e.res = s; e.wr = 1; e.dest = 1; end
      15: begin e.res = x; e.wr = 1; e.dest = 3; end
      16: mC = 0;
      17: mC = 1;
      18: mD = 0;
      19: mD = 1;
      20: mI = 0;
      21: mI = 1;
      22: mV = 0;
      default: ;
    endcase
    if ((op >= 1 && op <= 5) || (op >= 7 && op <= 14)) begin
      mN = (e.res >= 128); mZ = (e.res == 0);
    end
    e.st = stWord();
    @(negedge clk);
    opCode = op[4:0]; accIn = a[7:0]; xIn = x[7:0]; yIn = y[7:0];
    spIn = s[7:0]; memIn = m[7:0]; opValid = 1'b1;
    expQ.push_back(e);
  endtask

  task automatic idleCycle();
    @(negedge clk);
    opValid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (doneOut) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R2: done with no pending op, actual done=1 expected done=0");
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (wrEnOut != e.wr || (e.wr && (resultOut != e.res[7:0] || destOut != e.dest[1:0]))
              || statusOut != e.st[7:0]) begin
            errors++;
            $display("FAIL %s: actual wr=%0d res=%02h dest=%0d st=%02h expected wr=%0d res=%02h dest=%0d st=%02h",
                     e.tag, wrEnOut, resultOut, destOut, statusOut, e.wr, e.res[7:0], e.dest, e.st[7:0]);
          end
        end
      end else if (wrEnOut) begin
        checks++; errors++;
        $display("FAIL R2: actual wrEn=1 expected wrEn=0 without done");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    checks++;
    if (statusOut != 8'h04 || doneOut || wrEnOut) begin
      errors++;
      $display("FAIL R1: actual st=%02h done=%0d wr=%0d expected st=04 done=0 wr=0",
               statusOut, doneOut, wrEnOut);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R3 add, signed overflow and carry corners
    issueOp(1, 8'h50, 0, 0, 0, 8'h50, "R3");
    issueOp(17, 0, 0, 0, 0, 0, "R10");
    issueOp(1, 8'hFF, 0, 0, 0, 8'h00, "R3");
    issueOp(16, 0, 0, 0, 0, 0, "R10");
    issueOp(1, 8'h80, 0, 0, 0, 8'h80, "R3");
    issueOp(1, 8'h7F, 0, 0, 0, 8'h00, "R3");
    // R4 subtract
    issueOp(17, 0, 0, 0, 0, 0, "R10");
    issueOp(2, 8'h50, 0, 0, 0, 8'hF0, "R4");
    issueOp(2, 8'h50, 0, 0, 0, 8'hB0, "R4");
    issueOp(16, 0, 0, 0, 0, 0, "R10");
    issueOp(2, 8'h00, 0, 0, 0, 8'h00, "R4");
    issueOp(2, 8'h80, 0, 0, 0, 8'h01, "R4");
    // R5 compare: V held from previous
    issueOp(3, 8'h40, 0, 0, 0, 8'h40, "R5");
    issueOp(4, 0, 8'h10, 0, 0, 8'h20, "R5");
    issueOp(5, 0, 0, 8'hF0, 0, 8'h01, "R5");
    // R6 bit test, C held
    issueOp(6, 8'h3F, 0, 0, 0, 8'hC0, "R6");
    issueOp(6, 8'h01, 0, 0, 0, 8'h01, "R6");
    // R7 logic
    issueOp(7, 8'hF0, 0, 0, 0, 8'h0F, "R7");
    issueOp(8, 8'h80, 0, 0, 0, 8'h01, "R7");
    issueOp(9, 8'h5A, 0, 0, 0, 8'hFF, "R7");
    // R8 transfers
    issueOp(10, 8'h00, 8'h11, 8'h22, 8'h33, 0, "R8");
    issueOp(11, 8'h90, 8'h11, 8'h22, 8'h33, 0, "R8");
    issueOp(12, 8'h00, 8'h7E, 8'h22, 8'h33, 0, "R8");
    issueOp(13, 8'h00, 8'h11, 8'hFE, 8'h33, 0, "R8");
    issueOp(14, 8'h00, 8'h11, 8'h22, 8'h00, 0, "R8");
    // R9 X to S, flags untouched (N currently 0, Z 1)
    issueOp(15, 8'h00, 8'h80, 8'h22, 8'h33, 0, "R9");
    // R10 and R11: decimal mode does not change add
    issueOp(19, 0, 0, 0, 0, 0, "R10");
    issueOp(16, 0, 0, 0, 0, 0, "R10");
    issueOp(1, 8'h09, 0, 0, 0, 8'h01, "R11");
    issueOp(2, 8'h10, 0, 0, 0, 8'h01, "R11");
    issueOp(18, 0, 0, 0, 0, 0, "R10");
    issueOp(20, 0, 0, 0, 0, 0, "R10");
    issueOp(21, 0, 0, 0, 0, 0, "R10");
    issueOp(6, 8'h00, 0, 0, 0, 8'h40, "R6");
    issueOp(22, 0, 0, 0, 0, 0, "R10");
    // R12 unassigned codes and the no-op
    issueOp(0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R12");
    issueOp(23, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R12");
    issueOp(31, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R12");
    // R13 layout: set all flags then read word
    issueOp(17, 0, 0, 0, 0, 0, "R13");
    issueOp(19, 0, 0, 0, 0, 0, "R13");
    issueOp(6, 8'h00, 0, 0, 0, 8'hC0, "R13");
    idleCycle();
    @(negedge clk);
    held = statusOut;
    repeat (3) @(negedge clk);
    checks++;
    if (statusOut != held || doneOut || wrEnOut) begin
      errors++;
      $display("FAIL R2: idle actual st=%02h done=%0d expected st=%02h done=0",
               statusOut, doneOut, held);
    end
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: actual pending=%0d expected pending=0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule